// File: doc/BRIEF.md
# DMA Command to Memory Request Splitter

This block takes one DMA command at a time: a 64-bit start address, a byte count and a direction. It breaks the command into a series of memory request descriptors for a downstream packet builder. A write command produces posted memory-write requests, and each one carries no more payload than the selected maximum payload size. A read command produces non-posted memory-read requests, and each one asks for no more than the selected maximum read request size. No request ever spans a 4 KB address boundary. When the start address is not 4 KB aligned, the first request is cut short so that the following requests start on the boundary.

Each descriptor gives the start address, the length in DWords, the request class, a flag saying the 32-bit address form is enough, and a flag marking the final request of the command. When a command has finished, the block pulses `done` for one cycle. In that same cycle it presents the total header overhead that the command costs, counted at 16 bytes per request. Commands are taken over a valid/ready pair and descriptors leave over a valid/ready pair. The size selections are sampled at the moment a command is accepted.

Top module: `dma_req_splitter`

## Requirements
- R1: For a write command, every request carries at most the payload limit picked by `mps_sel`: 0 selects 128 bytes, 1 selects 256, 2 selects 512, and 3 also selects 512. A 4 KB aligned write therefore yields 32, 16 or 8 requests.
- R2: For a read command, every request asks for at most 128 << `mrrs_sel` bytes when `mrrs_sel` is 0 to 5. A value of 6 or 7 selects 4096 bytes.
- R3: A request never spans a 4 KB address boundary. Each request has the largest length allowed by the remaining bytes, the size limit and the distance to the next boundary, so an unaligned start produces a shortened first request.
- R4: `req_posted` is 1 on every request of a write command and 0 on every request of a read command.
- R5: `req_dw` gives the request length in DWords and is never zero. Bits [1:0] of `cmd_addr` and `cmd_len` are ignored and treated as zero. Successive requests cover consecutive addresses.
- R6: A command whose DWord count is zero produces no request. `done` pulses in the cycle after it is accepted, with `hdr_bytes` equal to 0.
- R7: `done` pulses in the cycle after the final request is accepted. In that cycle `hdr_bytes` equals 16 times the number of requests the command produced.
- R8: `req_addr32` is 1 exactly when bits [63:32] of `req_addr` are all zero.
- R9: While `req_valid` is high and `req_ready` is low, all request fields stay unchanged in the next cycle. `cmd_ready` is low while a command is being split.
- R10: `req_last` is 1 only on the final request of a command.
- R11: `mps_sel` and `mrrs_sel` are sampled when a command is accepted. Changing them while the command is being split has no effect on its requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can accept a command |
| cmd_addr | input | 64 | Start address of the command, in bytes |
| cmd_len | input | 24 | Byte count of the command |
| cmd_write | input | 1 | 1 selects a write command, 0 a read command |
| mps_sel | input | 2 | Selects the write payload limit |
| mrrs_sel | input | 3 | Selects the read request limit |
| req_valid | output | 1 | A request descriptor is offered |
| req_ready | input | 1 | Downstream takes the descriptor |
| req_addr | output | 64 | Start address of the request |
| req_dw | output | 11 | Request length in DWords |
| req_posted | output | 1 | 1 for a posted write, 0 for a non-posted read |
| req_addr32 | output | 1 | The 32-bit address form is enough |
| req_last | output | 1 | Final request of the command |
| done | output | 1 | One-cycle pulse when a command has finished |
| hdr_bytes | output | 28 | Header overhead of the finished command, valid with done |

## Verification
The bench starts a command at 0x0F80, 128 bytes below a 4 KB boundary. A design that checked only the size limit would issue a 512-byte request across the boundary, and one that aligned to the payload size would chop the tail wrongly. An 8 KB read that starts at 0xFFFFF000 moves from one side of the 4 GB line to the other between its two requests. A stale or wrongly decoded `req_addr32` shows up there. Zero-length commands, sub-DWord lengths and lengths with stray low bits catch a design that emits an empty request, never pulses `done`, or rounds up instead of dropping the low bits. Runs under backpressure and runs with the size selections changed in mid-command catch a request that moves while it is stalled and a limit that is read live rather than latched.

// File: rtl/dmasplit_pkg.sv
package dmasplit_pkg;

   typedef enum logic [0:0] {
      SPL_IDLE = 1'b0,
      SPL_SEND = 1'b1
   } spl_state_e;

   function automatic int spl_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int spl_min(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/dmasplit_limit.sv
// Turns a size selection code into a byte limit that is a power of two.
// Codes above MAX_SEL clamp to the largest size.
module dmasplit_limit #(
   parameter int SEL_W   = 2,
   parameter int MIN_LG  = 7,
   parameter int MAX_SEL = 2,
   parameter int CHUNK_W = 13
) (
   input  logic [SEL_W-1:0]   sel,
   output logic [CHUNK_W-1:0] limit_bytes
);
   import dmasplit_pkg::*;

   localparam int N_CODES = 1 << SEL_W;

   if (MIN_LG + MAX_SEL >= CHUNK_W) begin : g_bad_width
      $error("dmasplit_limit: CHUNK_W too narrow for largest size");
   end
   if (MAX_SEL >= N_CODES) begin : g_bad_sel
      $error("dmasplit_limit: MAX_SEL not reachable with SEL_W bits");
   end

   logic [CHUNK_W-1:0] size_lut [N_CODES];

   for (genvar i = 0; i < N_CODES; i++) begin : g_lut
      localparam int EFF_SEL = spl_min(i, MAX_SEL);
      assign size_lut[i] = CHUNK_W'(1) << (MIN_LG + EFF_SEL);
   end

   assign limit_bytes = size_lut[sel];

endmodule

// File: rtl/dmasplit_chunk.sv
// Picks the length of the next request: the smallest of the remaining
// bytes, the size limit and the distance to the next boundary.
module dmasplit_chunk #(
   parameter int BOUNDARY_LG = 12,
   parameter int LEN_W       = 24,
   parameter int CHUNK_W     = 13
) (
   input  logic [BOUNDARY_LG-1:0] addr_lo,
   input  logic [LEN_W-1:0]       remain,
   input  logic [CHUNK_W-1:0]     limit_bytes,
   output logic [CHUNK_W-1:0]     chunk_bytes,
   output logic                   final_chunk
);
   import dmasplit_pkg::*;

   localparam int CMP_W = spl_max(LEN_W, CHUNK_W) + 1;

   if (CHUNK_W <= BOUNDARY_LG) begin : g_bad_width
      $error("dmasplit_chunk: CHUNK_W must hold a full boundary span");
   end

   logic [CHUNK_W-1:0] to_boundary;
   logic [CHUNK_W-1:0] cap;
   logic [CMP_W-1:0]   remain_ext;
   logic [CMP_W-1:0]   cap_ext;

   always_comb begin
      to_boundary = (CHUNK_W'(1) << BOUNDARY_LG) - CHUNK_W'(addr_lo);
      cap         = (limit_bytes < to_boundary) ? limit_bytes : to_boundary;
      remain_ext  = CMP_W'(remain);
      cap_ext     = CMP_W'(cap);
      final_chunk = (remain_ext <= cap_ext);
      chunk_bytes = final_chunk ? CHUNK_W'(remain) : cap;
   end

endmodule

// File: rtl/dma_req_splitter.sv
module dma_req_splitter #(
   parameter int ADDR_W        = 64,
   parameter int LEN_W         = 24,
   parameter int BOUNDARY_LG   = 12,
   parameter int MIN_SIZE_LG   = 7,
   parameter int WR_SEL_W      = 2,
   parameter int WR_MAX_SEL    = 2,
   parameter int RD_SEL_W      = 3,
   parameter int RD_MAX_SEL    = 5,
   parameter int HDR_LG        = 4,
   localparam int CHUNK_W      = dmasplit_pkg::spl_max(BOUNDARY_LG, MIN_SIZE_LG + RD_MAX_SEL) + 1,
   localparam int DW_W         = CHUNK_W - 2,
   localparam int HDR_W        = LEN_W + HDR_LG
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [ADDR_W-1:0]   cmd_addr,
   input  logic [LEN_W-1:0]    cmd_len,
   input  logic                cmd_write,
   input  logic [WR_SEL_W-1:0] mps_sel,
   input  logic [RD_SEL_W-1:0] mrrs_sel,
   output logic                req_valid,
   input  logic                req_ready,
   output logic [ADDR_W-1:0]   req_addr,
   output logic [DW_W-1:0]     req_dw,
   output logic                req_posted,
   output logic                req_addr32,
   output logic                req_last,
   output logic                done,
   output logic [HDR_W-1:0]    hdr_bytes
);
   import dmasplit_pkg::*;

   localparam int CNT_W        = LEN_W;
   localparam int WR_CAP_BYTES = 1 << (MIN_SIZE_LG + WR_MAX_SEL);
   localparam int RD_CAP_BYTES = 1 << (MIN_SIZE_LG + RD_MAX_SEL);
   localparam int SPAN_BYTES   = 1 << BOUNDARY_LG;

   if (ADDR_W <= 32) begin : g_bad_addr
      $error("dma_req_splitter: ADDR_W must exceed 32");
   end
   if (LEN_W < 3 || LEN_W >= ADDR_W) begin : g_bad_len
      $error("dma_req_splitter: LEN_W out of range");
   end
   if (BOUNDARY_LG < MIN_SIZE_LG + WR_MAX_SEL) begin : g_bad_bnd
      $error("dma_req_splitter: boundary smaller than write limit");
   end
   if (MIN_SIZE_LG < 2) begin : g_bad_min
      $error("dma_req_splitter: smallest size must be whole DWords");
   end

   spl_state_e         state_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [LEN_W-1:0]   remain_q;
   logic               write_q;
   logic [CHUNK_W-1:0] limit_q;
   logic [CNT_W-1:0]   count_q;
   logic               done_q;
   logic [HDR_W-1:0]   hdr_q;

   logic [CHUNK_W-1:0] wr_limit;
   logic [CHUNK_W-1:0] rd_limit;
   logic [CHUNK_W-1:0] chunk_bytes;
   logic               final_chunk;
   logic               cmd_take;
   logic               req_take;
   logic               cmd_empty;
   logic [CNT_W-1:0]   count_next;

   dmasplit_limit #(
      .SEL_W   (WR_SEL_W),
      .MIN_LG  (MIN_SIZE_LG),
      .MAX_SEL (WR_MAX_SEL),
      .CHUNK_W (CHUNK_W)
   ) u_wr_limit (
      .sel         (mps_sel),
      .limit_bytes (wr_limit)
   );

   dmasplit_limit #(
      .SEL_W   (RD_SEL_W),
      .MIN_LG  (MIN_SIZE_LG),
      .MAX_SEL (RD_MAX_SEL),
      .CHUNK_W (CHUNK_W)
   ) u_rd_limit (
      .sel         (mrrs_sel),
      .limit_bytes (rd_limit)
   );

   dmasplit_chunk #(
      .BOUNDARY_LG (BOUNDARY_LG),
      .LEN_W       (LEN_W),
      .CHUNK_W     (CHUNK_W)
   ) u_chunk (
      .addr_lo     (addr_q[BOUNDARY_LG-1:0]),
      .remain      (remain_q),
      .limit_bytes (limit_q),
      .chunk_bytes (chunk_bytes),
      .final_chunk (final_chunk)
   );

   assign cmd_ready  = (state_q == SPL_IDLE);
   assign cmd_take   = cmd_valid && cmd_ready;
   assign req_valid  = (state_q == SPL_SEND);
   assign req_take   = req_valid && req_ready;
   assign cmd_empty  = (cmd_len[LEN_W-1:2] == '0);
   assign count_next = count_q + CNT_W'(1);

   assign req_addr   = addr_q;
   assign req_dw     = chunk_bytes[CHUNK_W-1:2];
   assign req_posted = write_q;
   assign req_addr32 = (addr_q[ADDR_W-1:32] == '0);
   assign req_last   = final_chunk;
   assign done       = done_q;
   assign hdr_bytes  = hdr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SPL_IDLE;
         addr_q   <= '0;
         remain_q <= '0;
         write_q  <= 1'b0;
         limit_q  <= '0;
         count_q  <= '0;
         done_q   <= 1'b0;
         hdr_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SPL_IDLE: begin
               if (cmd_take) begin
                  addr_q   <= {cmd_addr[ADDR_W-1:2], 2'b00};
                  remain_q <= {cmd_len[LEN_W-1:2], 2'b00};
                  write_q  <= cmd_write;
                  limit_q  <= cmd_write ? wr_limit : rd_limit;
                  count_q  <= '0;
                  if (cmd_empty) begin
                     done_q <= 1'b1;
                     hdr_q  <= '0;
                  end else begin
                     state_q <= SPL_SEND;
                  end
               end
            end
            SPL_SEND: begin
               if (req_take) begin
                  addr_q   <= addr_q + ADDR_W'(chunk_bytes);
                  remain_q <= remain_q - LEN_W'(chunk_bytes);
                  count_q  <= count_next;
                  if (final_chunk) begin
                     state_q <= SPL_IDLE;
                     done_q  <= 1'b1;
                     hdr_q   <= HDR_W'(count_next) << HDR_LG;
                  end
               end
            end
            default: state_q <= SPL_IDLE;
         endcase
      end
   end

   AST_NO_4K_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ((CHUNK_W + 1)'(req_addr[BOUNDARY_LG-1:0]) + (CHUNK_W + 1)'({req_dw, 2'b00}))
                    <= (CHUNK_W + 1)'(SPAN_BYTES)); // R3

   AST_WR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_posted) |-> ({req_dw, 2'b00} <= CHUNK_W'(WR_CAP_BYTES))); // R1

   AST_RD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_posted) |-> ({req_dw, 2'b00} <= CHUNK_W'(RD_CAP_BYTES))); // R2

   AST_DW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_dw != '0)); // R5

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_dw)
                                     && $stable(req_posted) && $stable(req_last))); // R9

   AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !cmd_ready); // R9

   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_len[LEN_W-1:2] == '0) |=>
         (done && hdr_bytes == '0 && !req_valid)); // R6

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_last) |=> (done && !req_valid)); // R7

endmodule

// File: tb/dma_req_splitter_tb.sv
module dma_req_splitter_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [63:0] cmd_addr = '0;
   logic [23:0] cmd_len = '0;
   logic        cmd_write = 1'b0;
   logic [1:0]  mps_sel = '0;
   logic [2:0]  mrrs_sel = '0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [63:0] req_addr;
   logic [10:0] req_dw;
   logic        req_posted;
   logic        req_addr32;
   logic        req_last;
   logic        done;
   logic [27:0] hdr_bytes;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma_req_splitter u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_addr   (cmd_addr),
      .cmd_len    (cmd_len),
      .cmd_write  (cmd_write),
      .mps_sel    (mps_sel),
      .mrrs_sel   (mrrs_sel),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_dw     (req_dw),
      .req_posted (req_posted),
      .req_addr32 (req_addr32),
      .req_last   (req_last),
      .done       (done),
      .hdr_bytes  (hdr_bytes)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint unsigned act, input longint unsigned exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic longint unsigned next_chunk(input longint unsigned a,
                                                  input longint unsigned rem,
                                                  input longint unsigned lim);
      longint unsigned to_bnd = 64'd4096 - (a & 64'hFFF);
      longint unsigned c = rem;
      if (lim < c) c = lim;
      if (to_bnd < c) c = to_bnd;
      return c;
   endfunction

   // Issues one command and checks every request it yields plus the done pulse.
   task automatic run_cmd(input string name, input longint unsigned a, input int len,
                          input bit wr, input int mps, input int mrrs,
                          input bit stall, input bit swap_sel);
      longint unsigned lim;
      longint unsigned ea;
      longint unsigned erem;
      longint unsigned c;
      int exp_n = 0;
      int idx = 0;
      bit saw_done = 1'b0;
      lim  = wr ? (64'd128 << ((mps > 2) ? 2 : mps)) : (64'd128 << ((mrrs > 5) ? 5 : mrrs));
      ea   = a & ~64'd3;
      erem = longint'(len) & ~64'd3;
      while (erem != 0) begin
         c = next_chunk(ea, erem, lim);
         ea += c;
         erem -= c;
         exp_n++;
      end
      ea   = a & ~64'd3;
      erem = longint'(len) & ~64'd3;

      @(negedge clk);
      cmd_addr  = a;
      cmd_len   = 24'(len);
      cmd_write = wr;
      mps_sel   = 2'(mps);
      mrrs_sel  = 3'(mrrs);
      cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (swap_sel) begin
         mps_sel  = 2'(~mps);
         mrrs_sel = 3'd0;
      end

      for (int cyc = 0; cyc < 20000; cyc++) begin
         if (done) begin
            saw_done = 1'b1;
            break;
         end
         if (req_valid) begin
            c = next_chunk(ea, erem, lim);
            check(req_addr == ea, "R3", {name, " addr"}, req_addr, ea);
            check(longint'(req_dw) == c / 4, wr ? "R1" : "R2", {name, " dw"}, req_dw, c / 4);
            check(req_posted == wr, "R4", {name, " posted"}, req_posted, wr);
            check(req_last == (c == erem), "R10", {name, " last"}, req_last, c == erem);
            check(req_addr32 == (ea < 64'h1_0000_0000), "R8", {name, " addr32"},
                  req_addr32, ea < 64'h1_0000_0000);
            check(!cmd_ready, "R9", {name, " cmd_ready busy"}, cmd_ready, 0);
            req_ready = stall ? (cyc % 3 == 2) : 1'b1;
            if (req_ready) begin
               idx++;
               ea += c;
               erem -= c;
            end
         end else begin
            req_ready = 1'b0;
         end
         @(negedge clk);
      end
      req_ready = 1'b0;
      check(saw_done, "R7", {name, " done pulse"}, saw_done, 1);
      check(idx == exp_n, "R7", {name, " request count"}, idx, exp_n);
      check(longint'(hdr_bytes) == 16 * exp_n, "R7", {name, " hdr_bytes"}, hdr_bytes, 16 * exp_n);
      if (exp_n == 0)
         check(saw_done && hdr_bytes == 0, "R6", {name, " empty cmd"}, hdr_bytes, 0);
      @(negedge clk);
      check(!done, "R7", {name, " done single cycle"}, done, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(cmd_ready == 1'b1, "R9", "reset cmd_ready", cmd_ready, 1);
      check(req_valid == 1'b0, "R9", "reset req_valid", req_valid, 0);
      check(done == 1'b0, "R7", "reset done", done, 0);
   endtask

   task automatic t_write_sizes();
      run_cmd("R1 4K write mps128", 64'h0001_0000, 4096, 1, 0, 0, 0, 0);
      run_cmd("R1 4K write mps256", 64'h0002_0000, 4096, 1, 1, 0, 0, 0);
      run_cmd("R1 4K write mps512", 64'h0003_0000, 4096, 1, 2, 0, 0, 0);
      run_cmd("R1 write sel3 clamps", 64'h0004_0000, 2048, 1, 3, 0, 0, 0);
   endtask

   task automatic t_read_sizes();
      run_cmd("R2 read mrrs128", 64'h0005_0000, 1024, 0, 0, 0, 0, 0);
      run_cmd("R2 read mrrs4K", 64'h0006_0000, 4096, 0, 0, 5, 0, 0);
      run_cmd("R2 read sel7 clamps", 64'h0007_0000, 8192, 0, 0, 7, 0, 0);
   endtask

   task automatic t_boundary();
      run_cmd("R3 write unaligned 0F80", 64'h0000_0F80, 1024, 1, 2, 0, 0, 0);
      run_cmd("R3 read unaligned 0FFC", 64'h0000_0FFC, 4100, 0, 0, 5, 0, 0);
   endtask

   task automatic t_dword();
      run_cmd("R6 zero length", 64'h0000_1000, 0, 1, 2, 0, 0, 0);
      run_cmd("R5 R6 sub-dword length", 64'h0000_1000, 3, 0, 0, 2, 0, 0);
      run_cmd("R5 stray low bits", 64'h0000_2003, 262, 1, 0, 0, 0, 0);
   endtask

   task automatic t_addr32();
      run_cmd("R8 read across 4G", 64'h0000_0000_FFFF_F000, 8192, 0, 0, 5, 0, 0);
      run_cmd("R8 high write", 64'h0000_0010_0000_0200, 512, 1, 1, 0, 0, 0);
   endtask

   task automatic t_stall();
      run_cmd("R9 write backpressure", 64'h0008_0E00, 1536, 1, 1, 0, 1, 0);
      run_cmd("R9 read backpressure", 64'h0009_0000, 2048, 0, 0, 1, 1, 0);
   endtask

   task automatic t_sel_latch();
      run_cmd("R11 write sel change", 64'h000A_0000, 2048, 1, 2, 0, 0, 1);
      run_cmd("R11 read sel change", 64'h000B_0000, 4096, 0, 0, 4, 0, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_sizes();
      t_read_sizes();
      t_boundary();
      t_dword();
      t_addr32();
      t_stall();
      t_sel_latch();
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule